// File: doc/BRIEF.md
# Dual-Channel Timer Compare Unit

This block pairs a free-running 16-bit up-counter with two compare channels. Each channel holds a 16-bit compare value. When the counter steps onto that value, the channel sets its match flag. It can then raise an interrupt, and it can drive its output pin to a programmed level. Software reaches the block over an 8-bit register bus.

The 16-bit registers move as whole words through one shared byte latch. Writing the upper byte parks it in the latch, and writing the lower byte commits both halves in one cycle. Reading the upper byte copies the lower half into the latch, so a later lower-byte read returns a consistent word even though the counter kept running in between.

A low-power mode input returns both compare values to all ones. It is used by the surrounding chip when it enters a sleep state.

Top module: `ocmp_unit`

## Requirements
- R1: The counter adds one on every cycle in which `cnt_en` is high and no word write targets it, wrapping from 0xFFFF to 0x0000; a word write to the counter loads it instead.
- R2: When a counter step produces a value equal to a channel's compare value, that channel's flag sets on the same clock edge that updates the counter; status bit 0 is channel A, bit 1 is channel B. A word write that loads the counter with that value sets no flag.
- R3: `irq_o[i]` is high exactly when flag i is set and interrupt-enable control bit i is 1, one cycle after either changes.
- R4: On a match, if output-enable control bit 2+i is 1, `cmp_pin_o[i]` takes the value of level control bit 4+i; with that enable at 0, or without a match, the pin keeps its value.
- R5: Each output pin is 0 from reset until that channel's first match.
- R6: Both compare values are 0xFFFF after reset, and they are forced to 0xFFFF on every cycle with `lp_mode` high; word writes to them during that time are discarded.
- R7: A write to an upper-byte address only loads the shared latch. A write to a lower-byte address stores {latch, data} into that word. The latch is shared, so an upper byte written for one word can complete a different word.
- R8: A read of an upper-byte address returns the upper half and latches the lower half. A read of a lower-byte address returns the latch contents. Read data appears on `bus_rdata` after the clock edge that samples `bus_rd`.
- R9: A flag clears only when status is written with that bit 0, provided the flag was read as 1 since the last status write. Writing 1, or writing 0 without such a read, leaves the flag set. Every status write ends the armed state.
- R10: If a match and a valid clear of the same flag fall in one cycle, the flag stays set.
- R11: The two channels are independent: a match, flag, interrupt or pin change on one leaves the other unchanged.
- R12: Address map: 0/1 counter upper/lower, 2/3 compare A upper/lower, 4/5 compare B upper/lower, 6 status, 7 control; control reads back as written and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_mode | input | 1 | Low-power mode; holds compare values at all ones |
| cnt_en | input | 1 | Single-cycle count enable |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 2 | Per-channel interrupt request |
| cmp_pin_o | output | 2 | Per-channel compare output pin |

## Verification
Two events can land in the same cycle: a counter step that matches channel A, and a software clear of flag A. The bench sets the flag and arms it with a status read. It then raises `cnt_en` in the same cycle as the status write of 0, with the counter one below the compare value. It passes if a following status read still returns 1. A normal read-then-clear must then bring the flag back to 0.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int OCMP_BYTE_W = 8;
  localparam int OCMP_NCH    = 2;

  function automatic int ocmp_stat_addr(input int nch);
    return 2 * (nch + 1);
  endfunction
endpackage

// File: rtl/ocmp_counter.sv
module ocmp_counter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              cnt_en,
  output logic [WORD_W-1:0] cnt_q,
  output logic [WORD_W-1:0] cnt_inc,
  output logic              step
);
  assign cnt_inc = cnt_q + 1'b1;
  assign step    = cnt_en && !load;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (step) cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lp_mode,
  input  logic              cmp_load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              step,
  input  logic [WORD_W-1:0] cnt_inc,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic              stat_wbit,
  input  logic              irq_en,
  input  logic              out_en,
  input  logic              out_lvl,
  output logic [WORD_W-1:0] cmp_q,
  output logic              match,
  output logic              flag_q,
  output logic              irq_q,
  output logic              pin_q
);
  logic armed_q;
  logic clr_req;
  logic flag_d;

  assign match   = step && (cnt_inc == cmp_q);
  assign clr_req = stat_wr && armed_q && !stat_wbit;
  assign flag_d  = match || (flag_q && !clr_req);

  always_ff @(posedge clk) begin
    if (rst || lp_mode) cmp_q <= '1;
    else if (cmp_load)  cmp_q <= load_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      if (stat_wr)               armed_q <= 1'b0;
      else if (stat_rd && flag_q) armed_q <= 1'b1;
      flag_q <= flag_d;
      irq_q  <= flag_d && irq_en;
      if (match && out_en) pin_q <= out_lvl;
    end
  end
endmodule

// File: rtl/ocmp_regbus.sv
module ocmp_regbus #(
  parameter int BYTE_W = 8,
  parameter int NCH    = 2,
  parameter int ADDR_W = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [BYTE_W-1:0]            bus_wdata,
  input  logic [2*BYTE_W-1:0]          cnt_q,
  input  logic [NCH-1:0][2*BYTE_W-1:0] cmp_q,
  input  logic [NCH-1:0]               flag_q,
  output logic [BYTE_W-1:0]            bus_rdata,
  output logic                         cnt_load,
  output logic [NCH-1:0]               cmp_load,
  output logic [2*BYTE_W-1:0]          word_wval,
  output logic                         stat_rd,
  output logic                         stat_wr,
  output logic [NCH-1:0]               stat_wdata,
  output logic [3*NCH-1:0]             ctrl_q
);
  localparam int WORD_W    = 2 * BYTE_W;
  localparam int NWORD     = NCH + 1;
  localparam int STAT_ADDR = ocmp_pkg::ocmp_stat_addr(NCH);
  localparam int CTRL_ADDR = STAT_ADDR + 1;
  localparam int CTRL_W    = 3 * NCH;

  logic [NWORD-1:0][WORD_W-1:0] words;
  logic [BYTE_W-1:0]            temp_q;
  logic                         is_word;
  logic                         is_hi;
  logic                         word_wr;
  logic                         ctrl_wr;
  logic [ADDR_W-1:0]            widx;

  always_comb begin
    words[0] = cnt_q;
    for (int i = 0; i < NCH; i++) words[i+1] = cmp_q[i];
  end

  assign is_word    = ({1'b0, bus_addr} < (ADDR_W+1)'(2 * NWORD));
  assign is_hi      = is_word && !bus_addr[0];
  assign widx       = bus_addr >> 1;
  assign word_wr    = bus_wr && is_word && bus_addr[0];
  assign word_wval  = {temp_q, bus_wdata};
  assign cnt_load   = word_wr && (widx == '0);
  assign stat_wr    = bus_wr && (bus_addr == ADDR_W'(STAT_ADDR));
  assign stat_rd    = bus_rd && (bus_addr == ADDR_W'(STAT_ADDR));
  assign ctrl_wr    = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
  assign stat_wdata = bus_wdata[NCH-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ld
    assign cmp_load[g] = word_wr && (widx == ADDR_W'(g + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      temp_q <= '0;
    end else if (bus_wr && is_hi) begin
      temp_q <= bus_wdata;
    end else if (bus_rd && is_hi && !bus_wr) begin
      temp_q <= words[widx][BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (is_hi)                                bus_rdata <= words[widx][WORD_W-1:BYTE_W];
      else if (is_word)                         bus_rdata <= temp_q;
      else if (bus_addr == ADDR_W'(STAT_ADDR))  bus_rdata <= BYTE_W'(flag_q);
      else                                      bus_rdata <= BYTE_W'(ctrl_q);
    end
  end
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit #(
  parameter int BYTE_W = ocmp_pkg::OCMP_BYTE_W,
  parameter int NCH    = ocmp_pkg::OCMP_NCH,
  parameter int ADDR_W = $clog2(ocmp_pkg::ocmp_stat_addr(NCH) + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lp_mode,
  input  logic              cnt_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq_o,
  output logic [NCH-1:0]    cmp_pin_o
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0]            cnt_q;
  logic [WORD_W-1:0]            cnt_inc;
  logic                         cnt_step;
  logic                         cnt_load;
  logic [NCH-1:0]               cmp_load;
  logic [WORD_W-1:0]            word_wval;
  logic [NCH-1:0][WORD_W-1:0]   cmp_q;
  logic [NCH-1:0]               flag_q;
  logic [NCH-1:0]               ch_match;
  logic                         stat_rd;
  logic                         stat_wr;
  logic [NCH-1:0]               stat_wdata;
  logic [3*NCH-1:0]             ctrl_q;

  ocmp_counter #(.WORD_W(WORD_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(word_wval),
    .cnt_en(cnt_en), .cnt_q(cnt_q), .cnt_inc(cnt_inc), .step(cnt_step)
  );

  ocmp_regbus #(.BYTE_W(BYTE_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .cnt_q(cnt_q), .cmp_q(cmp_q),
    .flag_q(flag_q), .bus_rdata(bus_rdata), .cnt_load(cnt_load),
    .cmp_load(cmp_load), .word_wval(word_wval), .stat_rd(stat_rd),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .ctrl_q(ctrl_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ocmp_channel #(.WORD_W(WORD_W)) u_ch (
      .clk(clk), .rst(rst), .lp_mode(lp_mode),
      .cmp_load(cmp_load[g]), .load_val(word_wval),
      .step(cnt_step), .cnt_inc(cnt_inc),
      .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wbit(stat_wdata[g]),
      .irq_en(ctrl_q[g]), .out_en(ctrl_q[NCH+g]), .out_lvl(ctrl_q[2*NCH+g]),
      .cmp_q(cmp_q[g]), .match(ch_match[g]), .flag_q(flag_q[g]),
      .irq_q(irq_o[g]), .pin_q(cmp_pin_o[g])
    );
  end
endmodule

// File: rtl/ocmp_unit_chk.sv
module ocmp_unit_chk #(
  parameter int NCH    = 2,
  parameter int WORD_W = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       lp_mode,
  input logic                       cnt_en,
  input logic                       cnt_load,
  input logic [WORD_W-1:0]          cnt_q,
  input logic [NCH-1:0]             ch_match,
  input logic [NCH-1:0]             flag_q,
  input logic [NCH-1:0]             irq_o,
  input logic [NCH-1:0]             cmp_pin_o,
  input logic [NCH-1:0][WORD_W-1:0] cmp_q
);
  logic [NCH-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else     seen_q <= seen_q | ch_match;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !cnt_load) |=> cnt_q == WORD_W'($past(cnt_q) + 1'b1)); // R1

  for (genvar g = 0; g < NCH; g++) begin : g_a
    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
      ch_match[g] |=> flag_q[g]); // R2
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
      irq_o[g] |-> flag_q[g]); // R3
    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
      !ch_match[g] |=> $stable(cmp_pin_o[g])); // R4
    AST_PIN_RESET_LOW: assert property (@(posedge clk) disable iff (rst)
      !seen_q[g] |-> !cmp_pin_o[g]); // R5
    AST_LP_ONES: assert property (@(posedge clk) disable iff (rst)
      lp_mode |=> cmp_q[g] == '1); // R6
  end
endmodule

bind ocmp_unit ocmp_unit_chk #(.NCH(NCH), .WORD_W(2*BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .lp_mode(lp_mode), .cnt_en(cnt_en),
  .cnt_load(cnt_load), .cnt_q(cnt_q), .ch_match(ch_match), .flag_q(flag_q),
  .irq_o(irq_o), .cmp_pin_o(cmp_pin_o), .cmp_q(cmp_q)
);

// File: tb/ocmp_unit_bench.sv
module ocmp_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lp_mode = 1'b0;
  logic       cnt_en = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] irq_o;
  logic [1:0] cmp_pin_o;

  int checks = 0;
  int errors = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  ocmp_unit u_ocmp_unit (
    .clk(clk), .rst(rst), .lp_mode(lp_mode), .cnt_en(cnt_en),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .cmp_pin_o(cmp_pin_o)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: pops the expected read data the driver queued
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string t);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", t, got, exp);
    end
  endtask

  task automatic wr_byte(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_word(input logic [2:0] a_hi, input logic [15:0] v);
    wr_byte(a_hi, v[15:8]);
    wr_byte(a_hi + 3'd1, v[7:0]);
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic step();
    cnt_en = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk(cmp_pin_o[0], 1'b0, "R5 pin A after reset");
    chk(cmp_pin_o[1], 1'b0, "R5 pin B after reset");
    chk(irq_o[0], 1'b0, "R3 irq A after reset");
    rd_chk(3'd2, 8'hFF, "R6 cmpA hi reset");
    rd_chk(3'd3, 8'hFF, "R6 cmpA lo reset");
    rd_chk(3'd4, 8'hFF, "R6 cmpB hi reset");
    rd_chk(3'd5, 8'hFF, "R6 cmpB lo reset");
    rd_chk(3'd6, 8'h00, "R2 status reset");
    rd_chk(3'd7, 8'h00, "R12 control reset");

    // R1 counting and wrap
    step(); step(); step();
    rd_chk(3'd0, 8'h00, "R1 count hi");
    rd_chk(3'd1, 8'h03, "R1 count lo");
    wr_word(3'd0, 16'hFFFF);
    step();
    rd_chk(3'd0, 8'h00, "R1 wrap hi");
    rd_chk(3'd1, 8'h00, "R1 wrap lo");

    // channel A match, output level 1
    wr_byte(3'd7, 8'h15);
    rd_chk(3'd7, 8'h15, "R12 control readback");
    wr_word(3'd2, 16'h0005);
    wr_word(3'd0, 16'h0003);
    step();
    chk(cmp_pin_o[0], 1'b0, "R5 pin A before first match");
    rd_chk(3'd6, 8'h00, "R2 no flag before match");
    step();
    chk(cmp_pin_o[0], 1'b1, "R4 pin A takes level 1");
    chk(irq_o[0], 1'b1, "R3 irq A raised");
    chk(irq_o[1], 1'b0, "R11 irq B untouched");
    chk(cmp_pin_o[1], 1'b0, "R11 pin B untouched");
    rd_chk(3'd6, 8'h01, "R2 flag A set");
    wr_byte(3'd6, 8'h00);
    rd_chk(3'd6, 8'h00, "R9 clear after read");
    chk(irq_o[0], 1'b0, "R3 irq A drops with flag");

    // output disabled: pin holds
    wr_byte(3'd7, 8'h01);
    wr_word(3'd0, 16'h0004);
    step();
    chk(cmp_pin_o[0], 1'b1, "R4 pin holds with output disabled");
    rd_chk(3'd6, 8'h01, "R2 flag with output disabled");
    wr_byte(3'd7, 8'h00);
    @(negedge clk);
    chk(irq_o[0], 1'b0, "R3 irq off when disabled");
    wr_byte(3'd6, 8'h00);
    rd_chk(3'd6, 8'h00, "R9 clear");

    // clear without prior read, and write of 1
    wr_word(3'd0, 16'h0004);
    step();
    wr_byte(3'd6, 8'h00);
    rd_chk(3'd6, 8'h01, "R9 unarmed write ignored");
    wr_byte(3'd6, 8'h01);
    rd_chk(3'd6, 8'h01, "R9 write one ignored");
    wr_byte(3'd6, 8'h00);
    rd_chk(3'd6, 8'h00, "R9 armed clear");

    // output level 0
    wr_byte(3'd7, 8'h05);
    wr_word(3'd0, 16'h0004);
    step();
    chk(cmp_pin_o[0], 1'b0, "R4 pin A takes level 0");
    chk(irq_o[0], 1'b1, "R3 irq A again");
    rd_chk(3'd6, 8'h01, "R2 flag A again");

    // R10: match and clear in the same cycle
    wr_word(3'd0, 16'h0004);
    rd_chk(3'd6, 8'h01, "R2 load sets no new flag state");
    bus_addr = 3'd6; bus_wdata = 8'h00; bus_wr = 1'b1; cnt_en = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; cnt_en = 1'b0;
    rd_chk(3'd6, 8'h01, "R10 match wins over clear");
    wr_byte(3'd6, 8'h00);
    rd_chk(3'd6, 8'h00, "R10 later clear works");

    // channel B
    wr_byte(3'd7, 8'h2A);
    wr_word(3'd4, 16'h0020);
    wr_word(3'd0, 16'h001F);
    step();
    chk(cmp_pin_o[1], 1'b1, "R4 pin B takes level 1");
    chk(irq_o[1], 1'b1, "R3 irq B raised");
    chk(cmp_pin_o[0], 1'b0, "R11 pin A untouched");
    chk(irq_o[0], 1'b0, "R11 irq A untouched");
    rd_chk(3'd6, 8'h02, "R11 only flag B");

    // R8 atomic read
    wr_word(3'd0, 16'h12FE);
    rd_chk(3'd0, 8'h12, "R8 hi read");
    step(); step();
    rd_chk(3'd1, 8'hFE, "R8 lo from latch");
    rd_chk(3'd0, 8'h13, "R8 hi after count");
    rd_chk(3'd1, 8'h00, "R8 lo after count");

    // R7 write path and shared latch
    wr_word(3'd2, 16'hABCD);
    rd_chk(3'd2, 8'hAB, "R7 cmpA hi");
    rd_chk(3'd3, 8'hCD, "R7 cmpA lo");
    wr_byte(3'd2, 8'h11);
    wr_byte(3'd5, 8'h22);
    rd_chk(3'd4, 8'h11, "R7 shared latch hi");
    rd_chk(3'd5, 8'h22, "R7 shared latch lo");

    // R6 low-power mode
    lp_mode = 1'b1;
    @(negedge clk);
    lp_mode = 1'b0;
    rd_chk(3'd2, 8'hFF, "R6 lp cmpA hi");
    rd_chk(3'd3, 8'hFF, "R6 lp cmpA lo");
    rd_chk(3'd4, 8'hFF, "R6 lp cmpB hi");
    rd_chk(3'd5, 8'hFF, "R6 lp cmpB lo");
    lp_mode = 1'b1;
    wr_word(3'd2, 16'h1234);
    lp_mode = 1'b0;
    rd_chk(3'd2, 8'hFF, "R6 write during lp discarded hi");
    rd_chk(3'd3, 8'hFF, "R6 write during lp discarded lo");

    finish_run();
  end
endmodule